// File: doc/BRIEF.md
# Halt Mode Power Sequencer

This block steps a processor core into a deep halt state and brings it back out. When software issues an idle request, the core clock keeps running for a drain period so that the pipeline and any pending transfers can complete. The drain period is set by the clock divider select code. When the drain period ends, the core and peripheral clocks are gated off and the PLL is powered down. The oscillator is also powered down, but only when the clock source is an external crystal or resonator. Two internal oscillators and the watchdog each have a keep-alive bit that lets them stay running while the block is halted.

A falling edge on the wake pin is captured by a latch that needs no running clock. The captured flag is then brought into the reference clock domain through a two-stage synchronizer. Wake edges that arrive too soon after halt entry are discarded. An accepted wake powers the oscillator back up and waits for the oscillator-stable indication. It then times a PLL lock wait, turns the core and peripheral clocks back on in the same cycle, and raises a one-cycle wake interrupt if that interrupt is enabled. The block then returns to its run state. The sequencer runs on the reference clock. The analog behaviour of the oscillator and the PLL is not modelled.

Top module: `halt_sequencer`

## Requirements
- R1: After reset the block is in its run state. The core and peripheral clock enables are 1, both power-down outputs are 0, all three keep-alive run outputs are 1 and the wake interrupt is 0.
- R2: An idle request seen in the run state starts the drain. The core clock enable stays 1 for the next DRAIN_BASE cycles when the divider select is 2'b00 or 2'b01, for 2*DRAIN_BASE cycles when it is 2'b10, and for 4*DRAIN_BASE cycles when it is 2'b11. The divider select is sampled in the cycle of the request; later changes have no effect.
- R3: In the cycle the drain ends, the core clock enable and the peripheral clock enable both go to 0 and the PLL power-down goes to 1.
- R4: While halted, the oscillator power-down is 1 when the clock-source input is 1 (crystal or resonator) and 0 when it is 0. Outside the halted state it is 0.
- R5: While halted, each keep-alive run output (internal oscillator 1, internal oscillator 2, watchdog) equals its own keep-alive input. In every other state each is 1.
- R6: A falling wake-pin edge accepted in the halted state takes the block out of halt on the third rising clock edge after the fall. At that point the oscillator power-down goes to 0, while the PLL power-down stays 1 until the oscillator-stable input is seen high.
- R7: A wake-pin falling edge less than WAKE_MIN cycles after the idle request was accepted is discarded. The block stays halted and waits for a later edge.
- R8: On the first edge where the oscillator-stable input is high, the PLL power-down goes to 0. The clocks stay off for exactly LOCK_CYCLES cycles. On the next edge the core and peripheral clock enables return to 1 together.
- R9: The wake interrupt is a one-cycle pulse in the cycle the clocks return, and only when the interrupt-enable input is 1. In the following cycle the block is back in its run state.
- R10: An idle request and a wake-pin fall arriving together in the run state produce a normal halt entry, and that wake edge is discarded.
- R11: An idle request outside the run state is ignored. It neither restarts the drain nor starts a new halt after the block returns to run.
- R12: A wake edge accepted late in the drain does not cut the drain short. The block reaches the halted state and leaves it on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (oscillator) clock for the sequencer |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_req_i | input | 1 | Request to enter halt |
| div_sel_i | input | 2 | Divider select code; sets the drain length |
| xtal_src_i | input | 1 | 1 when the clock source is a crystal or resonator |
| keep_intosc1_i | input | 1 | Keep internal oscillator 1 running in halt |
| keep_intosc2_i | input | 1 | Keep internal oscillator 2 running in halt |
| keep_wdog_i | input | 1 | Keep the watchdog running in halt |
| wake_n_i | input | 1 | Wake pin; a falling edge requests wake-up |
| osc_stable_i | input | 1 | Oscillator reports a stable output |
| wake_irq_en_i | input | 1 | Enables the wake interrupt request |
| core_clk_en_o | output | 1 | Core clock gate enable |
| periph_clk_en_o | output | 1 | Peripheral clock gate enable |
| pll_pd_o | output | 1 | PLL power-down |
| osc_pd_o | output | 1 | Oscillator power-down |
| intosc1_run_o | output | 1 | Internal oscillator 1 run enable |
| intosc2_run_o | output | 1 | Internal oscillator 2 run enable |
| wdog_run_o | output | 1 | Watchdog run enable |
| wake_irq_o | output | 1 | One-cycle wake interrupt request |

## Verification
The bench counts the drain for every divider code and checks the exact cycle the clocks stop. A design with an off-by-one counter, or one that re-reads the divider select mid-drain, would stop the clocks one cycle early or late, or would change the drain length when the divider select changes during the drain. It sends a wake edge inside the minimum window, and another together with the idle request. A design that latches either one would leave halt at once, which shows up as the PLL power-down dropping while it should still be high. It also sends a wake edge late in the drain and idle requests during the drain and during the lock wait. These catch a design that aborts the drain, that halts again right after resuming, or that lets the interrupt pulse last longer than one cycle or fire while disabled.

// File: rtl/hseq_pkg.sv
// Shared definitions for the halt sequencer.
// Assumes: state codes are one-hot, and the drain length scales with the divider code.
package hseq_pkg;

    typedef enum logic [5:0] {
        ST_RUN    = 6'b000001,
        ST_DRAIN  = 6'b000010,
        ST_HALT   = 6'b000100,
        ST_OSC    = 6'b001000,
        ST_LOCK   = 6'b010000,
        ST_RESUME = 6'b100000
    } hseq_state_e;

    // Number of drain cycles for a divider select code.
    function automatic int unsigned drain_cycles(input logic [1:0] sel, input int unsigned base);
        case (sel)
            2'b10:   return base * 2;
            2'b11:   return base * 4;
            default: return base;
        endcase
    endfunction

endpackage

// File: rtl/hseq_wake.sv
// Wake capture for the halt sequencer. A latch set by the falling edge of the
// wake pin works without a clock. It is held clear unless the guard window since
// halt entry has elapsed and the sequencer is draining or halted. The captured
// flag then passes through a synchronizer in the reference clock domain.
// Assumes: the wake pin is glitch free and meets the minimum pulse width.
module hseq_wake
    import hseq_pkg::*;
#(
    parameter int unsigned WAKE_MIN    = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  hseq_state_e state_i,
    input  logic        wake_n_i,
    output logic        wake_seen_o
);
    localparam int unsigned WW = $clog2(WAKE_MIN + 1);

    logic [WW-1:0]          win_q;
    logic                   armed_q;
    logic                   latch_clr;
    logic                   latch_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   guard_state;

    assign guard_state = (state_i == ST_DRAIN) || (state_i == ST_HALT);

    // Count cycles since halt entry, saturating at the guard length.
    always_ff @(posedge clk) begin
        if (!rst_n || !guard_state)
            win_q <= '0;
        else if (win_q != WW'(WAKE_MIN))
            win_q <= win_q + 1'b1;
    end

    // Register the arm condition so the latch clear is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else
            armed_q <= guard_state && (win_q == WW'(WAKE_MIN));
    end

    assign latch_clr = !armed_q || !rst_n;

    // Capture the wake pin fall while clocks may be stopped.
    always_ff @(negedge wake_n_i or posedge latch_clr) begin
        if (latch_clr)
            latch_q <= 1'b0;
        else
            latch_q <= 1'b1;
    end

    // Bring the captured flag into the reference clock domain.
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= latch_q;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], latch_q};
            end
        end
    endgenerate

    assign wake_seen_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/hseq_fsm.sv
// Halt sequencer state machine with one shared cycle counter. The counter
// times the drain (whose length is fixed when the idle request is accepted)
// and the PLL lock wait.
// Assumes: osc_stable_i is synchronous to clk.
module hseq_fsm
    import hseq_pkg::*;
#(
    parameter int unsigned DRAIN_BASE  = 16,
    parameter int unsigned LOCK_CYCLES = 10000,
    parameter int unsigned CW          = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        idle_req_i,
    input  logic [1:0]  div_sel_i,
    input  logic        wake_seen_i,
    input  logic        osc_stable_i,
    output hseq_state_e state_o
);
    hseq_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, lim_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:    if (idle_req_i)              state_d = ST_DRAIN;
            ST_DRAIN:  if (cnt_q == lim_q)          state_d = ST_HALT;
            ST_HALT:   if (wake_seen_i)             state_d = ST_OSC;
            ST_OSC:    if (osc_stable_i)            state_d = ST_LOCK;
            ST_LOCK:   if (cnt_q == CW'(LOCK_CYCLES - 1)) state_d = ST_RESUME;
            ST_RESUME:                              state_d = ST_RUN;
            default:                                state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Cycle counter: cleared on every transition, counts during drain and lock.
    always_ff @(posedge clk) begin
        if (!rst_n || state_d != state_q)
            cnt_q <= '0;
        else if (state_q == ST_DRAIN || state_q == ST_LOCK)
            cnt_q <= cnt_q + 1'b1;
    end

    // Drain limit, sampled from the divider select when the request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim_q <= CW'(DRAIN_BASE - 1);
        else if (state_q == ST_RUN && idle_req_i)
            lim_q <= CW'(drain_cycles(div_sel_i, DRAIN_BASE) - 1);
    end

    assign state_o = state_q;

endmodule

// File: rtl/hseq_outdec.sv
// Output decode for the halt sequencer: clock gates, power-down enables,
// keep-alive run enables and the wake interrupt, all from the one-hot state.
// Assumes: configuration inputs are stable while halted.
module hseq_outdec
    import hseq_pkg::*;
#(
    parameter int unsigned N_KEEP = 3
) (
    input  hseq_state_e       state_i,
    input  logic              xtal_src_i,
    input  logic [N_KEEP-1:0] keep_i,
    input  logic              irq_en_i,
    output logic              core_clk_en_o,
    output logic              periph_clk_en_o,
    output logic              pll_pd_o,
    output logic              osc_pd_o,
    output logic [N_KEEP-1:0] run_o,
    output logic              wake_irq_o
);
    logic halted;
    logic clocks_on;

    assign halted    = state_i[2];
    assign clocks_on = state_i[0] | state_i[1] | state_i[5];

    // Clock gates and power-down enables.
    always_comb begin
        core_clk_en_o   = clocks_on;
        periph_clk_en_o = clocks_on;
        pll_pd_o        = state_i[2] | state_i[3];
        osc_pd_o        = halted & xtal_src_i;
        wake_irq_o      = state_i[5] & irq_en_i;
    end

    // One run enable for each keep-alive domain.
    generate
        for (genvar gi = 0; gi < N_KEEP; gi++) begin : g_keep
            assign run_o[gi] = !halted || keep_i[gi];
        end
    endgenerate

endmodule

// File: rtl/halt_sequencer.sv
// Top of the halt mode power sequencer. It connects the wake capture, the
// state machine and the output decode.
// Assumes: clk is the free-running reference clock; the analog oscillator and
// PLL are outside this block.
module halt_sequencer
    import hseq_pkg::*;
#(
    parameter int unsigned DRAIN_BASE  = 16,
    parameter int unsigned WAKE_MIN    = 5,
    parameter int unsigned LOCK_CYCLES = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req_i,
    input  logic [1:0] div_sel_i,
    input  logic       xtal_src_i,
    input  logic       keep_intosc1_i,
    input  logic       keep_intosc2_i,
    input  logic       keep_wdog_i,
    input  logic       wake_n_i,
    input  logic       osc_stable_i,
    input  logic       wake_irq_en_i,
    output logic       core_clk_en_o,
    output logic       periph_clk_en_o,
    output logic       pll_pd_o,
    output logic       osc_pd_o,
    output logic       intosc1_run_o,
    output logic       intosc2_run_o,
    output logic       wdog_run_o,
    output logic       wake_irq_o
);
    localparam int unsigned MAXC = (LOCK_CYCLES > 4 * DRAIN_BASE) ? LOCK_CYCLES : 4 * DRAIN_BASE;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    hseq_state_e state_q;
    logic        wake_seen;
    logic [2:0]  run_vec;

    hseq_wake #(.WAKE_MIN(WAKE_MIN), .SYNC_STAGES(2)) u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state_q),
        .wake_n_i    (wake_n_i),
        .wake_seen_o (wake_seen)
    );

    hseq_fsm #(.DRAIN_BASE(DRAIN_BASE), .LOCK_CYCLES(LOCK_CYCLES), .CW(CW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_req_i   (idle_req_i),
        .div_sel_i    (div_sel_i),
        .wake_seen_i  (wake_seen),
        .osc_stable_i (osc_stable_i),
        .state_o      (state_q)
    );

    hseq_outdec #(.N_KEEP(3)) u_dec (
        .state_i         (state_q),
        .xtal_src_i      (xtal_src_i),
        .keep_i          ({keep_wdog_i, keep_intosc2_i, keep_intosc1_i}),
        .irq_en_i        (wake_irq_en_i),
        .core_clk_en_o   (core_clk_en_o),
        .periph_clk_en_o (periph_clk_en_o),
        .pll_pd_o        (pll_pd_o),
        .osc_pd_o        (osc_pd_o),
        .run_o           (run_vec),
        .wake_irq_o      (wake_irq_o)
    );

    assign intosc1_run_o = run_vec[0];
    assign intosc2_run_o = run_vec[1];
    assign wdog_run_o    = run_vec[2];

endmodule

// File: rtl/hseq_chk.sv
// Property checker for the halt sequencer, attached to the top by bind.
// Assumes: reset is held low for at least two clock edges at start.
module hseq_chk
    import hseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       idle_req_i,
    input logic       xtal_src_i,
    input logic       wake_irq_en_i,
    input logic       core_clk_en_o,
    input logic       periph_clk_en_o,
    input logic       pll_pd_o,
    input logic       osc_pd_o,
    input logic       wake_irq_o,
    input logic [5:0] state_q,
    input logic       wake_seen
);
    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);

    assert_drain_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && idle_req_i) |=> (state_q == ST_DRAIN));

    assert_clk_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en_o) |-> (pll_pd_o && !periph_clk_en_o && $past(state_q == ST_DRAIN)));

    assert_osc_pd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        osc_pd_o |-> (xtal_src_i && !core_clk_en_o));

    assert_halt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !wake_seen) |=> (state_q == ST_HALT));

    assert_clk_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en_o) |-> ($past(state_q == ST_LOCK) && periph_clk_en_o));

    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq_o |=> (!wake_irq_o && state_q == ST_RUN));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq_o |-> (wake_irq_en_i && core_clk_en_o));

endmodule

bind halt_sequencer hseq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .idle_req_i      (idle_req_i),
    .xtal_src_i      (xtal_src_i),
    .wake_irq_en_i   (wake_irq_en_i),
    .core_clk_en_o   (core_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .pll_pd_o        (pll_pd_o),
    .osc_pd_o        (osc_pd_o),
    .wake_irq_o      (wake_irq_o),
    .state_q         (state_q),
    .wake_seen       (wake_seen)
);

// File: tb/halt_sequencer_test.sv
module halt_sequencer_test;
    localparam int unsigned DB = 16;
    localparam int unsigned WM = 5;
    localparam int unsigned LK = 120;

    // Vector fields: [6:5] divider, [4] crystal, [3:1] keep {wdog,osc2,osc1}, [0] irq enable.
    localparam logic [6:0] VEC_TAB [6] = '{
        7'b00_1_000_1, 7'b01_0_111_0, 7'b10_1_101_1,
        7'b11_1_010_1, 7'b10_0_001_0, 7'b11_0_110_1
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic idle_req = 1'b0, xtal = 1'b0, k1 = 1'b0, k2 = 1'b0, kw = 1'b0;
    logic wake_n = 1'b1, osc_stable = 1'b0, irq_en = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic core_en, per_en, pll_pd, osc_pd, o1_run, o2_run, wd_run, irq;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    halt_sequencer #(.DRAIN_BASE(DB), .WAKE_MIN(WM), .LOCK_CYCLES(LK)) uut (
        .clk(clk), .rst_n(rst_n), .idle_req_i(idle_req), .div_sel_i(div_sel),
        .xtal_src_i(xtal), .keep_intosc1_i(k1), .keep_intosc2_i(k2), .keep_wdog_i(kw),
        .wake_n_i(wake_n), .osc_stable_i(osc_stable), .wake_irq_en_i(irq_en),
        .core_clk_en_o(core_en), .periph_clk_en_o(per_en), .pll_pd_o(pll_pd),
        .osc_pd_o(osc_pd), .intosc1_run_o(o1_run), .intosc2_run_o(o2_run),
        .wdog_run_o(wd_run), .wake_irq_o(irq)
    );

    function automatic int drain_len(input logic [1:0] s);
        return (s == 2'b11) ? 4 * DB : (s == 2'b10) ? 2 * DB : DB;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Issue an idle request and check the drain length and the halt outputs.
    task automatic enter_halt(input logic [1:0] d);
        div_sel = d; idle_req = 1'b1;
        cyc(1); idle_req = 1'b0;
        cyc(drain_len(d) - 1);
        chk("R2 clock on at last drain cycle", int'(core_en), 1);
        cyc(1);
        chk("R3 core clock off", int'(core_en), 0);
        chk("R3 periph clock off", int'(per_en), 0);
        chk("R3 pll powered down", int'(pll_pd), 1);
        chk("R4 osc power-down", int'(osc_pd), int'(xtal));
        chk("R5 keep-alive run", int'({wd_run, o2_run, o1_run}), int'({kw, k2, k1}));
    endtask

    // Wake from halt with the exact cycle timing, then check the return.
    task automatic wake_full();
        osc_stable = 1'b0; wake_n = 1'b0;
        cyc(3);
        chk("R6 oscillator restarted", int'(osc_pd), 0);
        chk("R6 pll still down", int'(pll_pd), 1);
        chk("R5 keep-alive outside halt", int'({wd_run, o2_run, o1_run}), 7);
        cyc(2);
        chk("R6 waits for stable", int'(pll_pd), 1);
        osc_stable = 1'b1; wake_n = 1'b1;
        cyc(1); osc_stable = 1'b0;
        chk("R8 pll powered up", int'(pll_pd), 0);
        cyc(LK - 1);
        chk("R8 clocks off through lock", int'(core_en), 0);
        cyc(1);
        chk("R8 core clock back", int'(core_en), 1);
        chk("R8 periph clock back", int'(per_en), 1);
        chk("R9 wake interrupt", int'(irq), int'(irq_en));
        cyc(1);
        chk("R9 interrupt single cycle", int'(irq), 0);
    endtask

    // Finish a wake already under way: wait for the clocks to return.
    task automatic wait_resume();
        for (int i = 0; i < LK + 20 && !core_en; i++) cyc(1);
        chk("R8 clocks returned", int'(core_en), 1);
        cyc(2);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1 core clock", int'(core_en), 1);
        chk("R1 periph clock", int'(per_en), 1);
        chk("R1 pll power-down", int'(pll_pd), 0);
        chk("R1 osc power-down", int'(osc_pd), 0);
        chk("R1 keep-alive", int'({wd_run, o2_run, o1_run}), 7);
        chk("R1 interrupt", int'(irq), 0);
        rst_n = 1'b1;
        cyc(2);

        // Table walk: full halt and wake for each configuration.
        for (int v = 0; v < 6; v++) begin
            xtal = VEC_TAB[v][4]; {kw, k2, k1} = VEC_TAB[v][3:1]; irq_en = VEC_TAB[v][0];
            enter_halt(VEC_TAB[v][6:5]);
            wake_full();
            cyc(2);
        end

        // R7: wake edge inside the guard window is discarded.
        xtal = 1'b1; osc_stable = 1'b1; irq_en = 1'b1;
        div_sel = 2'b00; idle_req = 1'b1;
        cyc(1); idle_req = 1'b0;
        cyc(1); wake_n = 1'b0;
        cyc(1); wake_n = 1'b1;
        cyc(40);
        chk("R7 early wake ignored, still halted", int'(pll_pd), 1);
        chk("R7 early wake ignored, clocks off", int'(core_en), 0);
        wake_n = 1'b0; cyc(4); wake_n = 1'b1;
        chk("R7 later wake accepted", int'(pll_pd), 0);
        wait_resume();

        // R10: idle and wake fall together in the run state.
        idle_req = 1'b1; wake_n = 1'b0;
        cyc(1); idle_req = 1'b0; wake_n = 1'b1;
        cyc(DB - 1);
        chk("R10 drain runs", int'(core_en), 1);
        cyc(11);
        chk("R10 wake with idle discarded", int'(pll_pd), 1);
        wake_n = 1'b0; cyc(4); wake_n = 1'b1;
        chk("R10 later wake accepted", int'(pll_pd), 0);
        wait_resume();

        // R12: wake accepted late in the drain; drain completes, then wakes.
        div_sel = 2'b11; idle_req = 1'b1;
        cyc(1); idle_req = 1'b0;
        cyc(10); wake_n = 1'b0;
        cyc(2); wake_n = 1'b1;
        cyc(4 * DB - 1 - 12);
        chk("R12 drain not cut short", int'(core_en), 1);
        cyc(1);
        chk("R12 halted after full drain", int'(pll_pd), 1);
        cyc(2);
        chk("R12 wakes right after halt", int'(pll_pd), 0);
        wait_resume();

        // R2 and R11: divider change and extra idle during drain and lock.
        osc_stable = 1'b0;
        div_sel = 2'b10; idle_req = 1'b1;
        cyc(1); idle_req = 1'b0; div_sel = 2'b00;
        cyc(5); idle_req = 1'b1;
        cyc(1); idle_req = 1'b0;
        cyc(2 * DB - 7);
        chk("R2 divider sampled at request", int'(core_en), 1);
        cyc(1);
        chk("R11 idle in drain ignored", int'(core_en), 0);
        wake_n = 1'b0; cyc(3); wake_n = 1'b1;
        osc_stable = 1'b1; cyc(1); osc_stable = 1'b0;
        cyc(3); idle_req = 1'b1;
        cyc(1); idle_req = 1'b0;
        wait_resume();
        cyc(4 * DB + 10);
        chk("R11 idle in lock ignored", int'(core_en), 1);

        summary();
    end
endmodule